// File: doc/BRIEF.md
# Fixed-Format Keyboard Serial Transceiver

This block is a full-duplex asynchronous serial link with one fixed character layout. A character is one low start bit, eight data bits with the least significant bit first, and two high stop bits. An external single-cycle tick, pulsing at sixteen times the bit rate, paces both directions, so the transmitter and the receiver always share one bit rate.

On the transmit side a one-cycle write strobe with a byte loads the shifter and starts a character at once. Any character already on the line is dropped, and the new one starts from its start bit. A status flag shows when the shifter is free again.

On the receive side the line is synchronised through two flops and then oversampled. A low pulse is accepted as a start bit only once it has lasted half a bit time. The assembled byte and a "receive full" flag appear partway through the last data bit. After that the receiver ignores the line until a read strobe clears the flag and re-arms it.

Top module: `kbd_serial_xcvr`

## Requirements
- R1: After reset `ser_out` is 1, `tx_idle` is 1 and `rx_ready` is 0.
- R2: A transmitted character holds each bit on `ser_out` for 16 ticks, in this order: a 0 start bit, data bits 0 to 7, then two 1 stop bits.
- R3: `tx_idle` is 0 from the cycle after `tx_load` and returns to 1 once the 16 ticks of the second stop bit have elapsed.
- R4: A `tx_load` that arrives while a character is being sent abandons that character, and a full character of the new byte follows from its start bit.
- R5: The receiver returns the byte it sampled near the centre of each data bit, with the first bit received placed in bit 0 of `rx_data`.
- R6: `rx_ready` rises during the last data bit (between 8 and 9 bit times after the start edge), before the stop bits begin.
- R7: A low pulse on `ser_in` shorter than 8 ticks does not start a reception, and a later valid character is received correctly.
- R8: While `rx_ready` is 1, activity on `ser_in` leaves `rx_data` and `rx_ready` unchanged.
- R9: `rx_take` while `rx_ready` is 1 clears `rx_ready` on the next cycle and re-enables reception of the next character.
- R10: `ser_out` is 1 whenever `tx_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Single-cycle pulse at 16 times the bit rate |
| ser_in | input | 1 | Asynchronous serial input line |
| ser_out | output | 1 | Serial output line, high when idle |
| tx_load | input | 1 | Strobe: load `tx_data` and start a character |
| tx_data | input | 8 | Byte to transmit |
| tx_idle | output | 1 | Transmitter free for a new byte |
| rx_take | input | 1 | Strobe: consume the received byte and re-arm |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | A received byte is waiting |

## Verification
The embedded properties assume that `os_tick` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that `ser_in` changes only at bit boundaries many ticks apart, so the two-flop synchroniser never sees chatter. The stimulus pulses the tick on every other clock and moves the serial line only in whole 32-clock bit cells, or in one deliberately short 8-clock glitch. Strobes are issued only as single cycles. Reads are issued only while the flag is up.

// File: rtl/kbd_serial_xcvr.sv
module kbd_serial_xcvr #(
  parameter int OVS   = 16,
  parameter int NBITS = 8,
  parameter int NSTOP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             ser_in,
  output logic             ser_out,
  input  logic             tx_load,
  input  logic [NBITS-1:0] tx_data,
  output logic             tx_idle,
  input  logic             rx_take,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_ready
);
  localparam int CW    = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int FRAME = 1 + NBITS + NSTOP;
  localparam int FW    = $clog2(FRAME + 1);
  localparam int BW    = $clog2(NBITS + 1);

  // transmitter
  logic             tx_busy;
  logic [CW-1:0]    tx_cnt;
  logic [FW-1:0]    tx_pos;
  logic [NBITS-1:0] tx_hold;
  logic [NBITS-1:0] tx_sh;
  logic             tx_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_idle <= 1'b1;
      tx_cnt  <= '0;
      tx_pos  <= '0;
      tx_hold <= '0;
    end else if (tx_load) begin
      tx_hold <= tx_data;
      tx_busy <= 1'b1;
      tx_idle <= 1'b0;
      tx_cnt  <= '0;
      tx_pos  <= '0;
    end else if (tx_busy && os_tick) begin
      if (tx_cnt == CW'(OVS - 1)) begin
        tx_cnt <= '0;
        if (tx_pos == FW'(FRAME - 1)) begin
          tx_busy <= 1'b0;
          tx_idle <= 1'b1;
        end else begin
          tx_pos <= tx_pos + 1'b1;
        end
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  assign tx_sh = tx_hold >> (tx_pos - FW'(1));

  always_comb begin
    if (tx_pos == '0)                tx_bit = 1'b0;
    else if (tx_pos <= FW'(NBITS))   tx_bit = tx_sh[0];
    else                             tx_bit = 1'b1;
  end

  assign ser_out = !tx_busy || tx_bit;

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_HOLD} rx_st_t;
  rx_st_t           rx_st;
  logic             rx_m, rx_s;
  logic [CW-1:0]    rx_cnt;
  logic [BW-1:0]    rx_n;
  logic [NBITS-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= ser_in;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st    <= RX_IDLE;
      rx_cnt   <= '0;
      rx_n     <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_ready <= 1'b0;
    end else begin
      case (rx_st)
        RX_IDLE:
          if (os_tick && !rx_s) begin
            rx_st  <= RX_START;
            rx_cnt <= CW'(1);
          end
        RX_START:
          if (os_tick) begin
            if (rx_s) begin
              rx_st <= RX_IDLE;
            end else if (rx_cnt == CW'(HALF - 1)) begin
              rx_st  <= RX_DATA;
              rx_cnt <= '0;
              rx_n   <= '0;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        RX_DATA:
          if (os_tick) begin
            if (rx_cnt == CW'(OVS - 1)) begin
              rx_cnt <= '0;
              rx_sh  <= {rx_s, rx_sh[NBITS-1:1]};
              if (rx_n == BW'(NBITS - 1)) begin
                rx_data  <= {rx_s, rx_sh[NBITS-1:1]};
                rx_ready <= 1'b1;
                rx_st    <= RX_HOLD;
              end else begin
                rx_n <= rx_n + 1'b1;
              end
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        RX_HOLD:
          if (rx_take) begin
            rx_ready <= 1'b0;
            rx_st    <= RX_IDLE;
          end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  // R3
  load_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_idle);

  // R10
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> ser_out);

  // R9
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && rx_take) |=> !rx_ready);

  // R8
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_take) |=> (rx_ready && $stable(rx_data)));

  // R6
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(os_tick));
endmodule

// File: tb/sim_kbd_serial_xcvr.sv
module sim_kbd_serial_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick;
  logic ser_in = 1'b1;
  logic ser_out;
  logic tx_load = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_idle;
  logic rx_take = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam int BITC = 32;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'h55, 8'hA6, 8'h81, 8'h3C};

  always #5 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;

  kbd_serial_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .ser_in(ser_in), .ser_out(ser_out),
    .tx_load(tx_load), .tx_data(tx_data), .tx_idle(tx_idle),
    .rx_take(rx_take), .rx_data(rx_data), .rx_ready(rx_ready));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rx_frame(input logic [7:0] b, input bit timing);
    ser_in = 1'b0;
    step(BITC);
    for (int i = 0; i < 8; i++) begin
      ser_in = b[i];
      if (i == 7 && timing) begin
        step(8);
        chk(rx_ready == 1'b0, "R6 early", rx_ready, 0);
        step(20);
        chk(rx_ready == 1'b1, "R6 mid-last-bit", rx_ready, 1);
        step(4);
      end else begin
        step(BITC);
      end
    end
    ser_in = 1'b1;
    step(2 * BITC);
  endtask

  task automatic take;
    rx_take = 1'b1;
    step(1);
    rx_take = 1'b0;
    chk(rx_ready == 1'b0, "R9 cleared", rx_ready, 0);
  endtask

  task automatic tx_expect(input logic [7:0] b);
    logic [10:0] fr;
    fr = {2'b11, b, 1'b0};
    tx_data = b;
    tx_load = 1'b1;
    step(1);
    tx_load = 1'b0;
    chk(tx_idle == 1'b0, "R3 busy", tx_idle, 0);
    step(15);
    for (int k = 0; k < 11; k++) begin
      chk(ser_out == fr[k], "R2 bit", ser_out, fr[k]);
      if (k == 10) chk(tx_idle == 1'b0, "R3 last stop", tx_idle, 0);
      step(BITC);
    end
    chk(tx_idle == 1'b1, "R3 done", tx_idle, 1);
    chk(ser_out == 1'b1, "R10 idle high", ser_out, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    chk(ser_out == 1'b1, "R1 ser_out", ser_out, 1);
    chk(tx_idle == 1'b1, "R1 tx_idle", tx_idle, 1);
    chk(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
    step(10);

    for (int v = 0; v < NV; v++) begin
      rx_frame(VEC[v], 1'b1);
      chk(rx_data == VEC[v], "R5 byte", rx_data, VEC[v]);
      take();
      tx_expect(VEC[v]);
    end

    // R4 abort and restart
    tx_data = 8'hA5;
    tx_load = 1'b1;
    step(1);
    tx_load = 1'b0;
    step(100);
    tx_expect(8'h3C);

    // R7 short glitch
    ser_in = 1'b0;
    step(8);
    ser_in = 1'b1;
    step(400);
    chk(rx_ready == 1'b0, "R7 glitch ignored", rx_ready, 0);
    rx_frame(8'h96, 1'b0);
    chk(rx_data == 8'h96, "R7 after glitch", rx_data, 8'h96);
    take();

    // R8 hold while full
    rx_frame(8'h5A, 1'b0);
    rx_frame(8'hC3, 1'b0);
    chk(rx_ready == 1'b1, "R8 flag held", rx_ready, 1);
    chk(rx_data == 8'h5A, "R8 byte held", rx_data, 8'h5A);
    take();
    step(20);
    chk(rx_ready == 1'b0, "R9 stays clear", rx_ready, 0);
    rx_frame(8'h0F, 1'b0);
    chk(rx_data == 8'h0F, "R9 re-armed", rx_data, 8'h0F);
    chk(rx_ready == 1'b1, "R9 re-armed flag", rx_ready, 1);
    take();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule